// File: doc/BRIEF.md
# TDM Slot-Selective Transmitter

This block places words on an outgoing time-division-multiplexed serial line that several transmitters share. A frame sync marks the first bit of slot 0. Each frame holds a fixed number of slots, one word per slot, sent most significant bit first. An ownership mask picks the slots this transmitter fills. In those slots it raises its output enable and drives data. In every other slot it keeps the enable low, so another transmitter can use the line.

Words come from two alternating memory buffers. Owned slots take the next word, in ascending slot order, from consecutive addresses of the current buffer. When the last word of a buffer has been taken, the block hands that buffer back, switches to the other one and pulses an interrupt. Software marks a buffer as refilled through a small register port. The ownership mask can be rewritten while the block runs; a new mask takes effect at the next frame sync. An input reports the slots that other transmitters on the line already own. Any requested slot that is also in that set is refused, and the refusal is recorded.

The serial bit rate is given by a one-cycle tick (`bit_en`) in the core clock domain. The memory read port is combinational: read data must be valid in the same cycle as the address.

Top module: `tdm_slot_tx`

## Requirements
- R1: A tick with `fsync` high starts bit 0 of slot 0. Each slot is WORD_W ticks long. After slot NUM_SLOTS-1 the block drives nothing until the next frame sync, and it drives nothing before the first one.
- R2: `sdo_oe` is high for exactly the ticks of owned slots. Whenever `sdo_oe` is low, `sdo` is 0. Both outputs change only on the clock edge that samples a tick.
- R3: A mask write (`reg_addr`=0, one bit per slot, bit n = slot n) becomes active at the next frame-sync tick. The frame in progress keeps its old ownership.
- R4: Mask bits that are also set in `foreign_mask` at write time are dropped, and `conflict` is set. `conflict` stays set until a write to `reg_addr`=2 with bit 1 set.
- R5: Each owned slot causes one read (`mem_rd` high during its first tick) at address {buffer, index}. The index starts at 0 and rises by one per owned slot. The word goes out MSB first in that slot.
- R6: After the BUF_WORDS-th read from a buffer, that buffer's ready flag clears and the other buffer becomes current. `irq` pulses for one cycle, with `irq_buf` giving the buffer just emptied.
- R7: An owned slot that starts while the current buffer is not ready sends zeros with `sdo_oe` high. The index does not advance, and the sticky `underrun` is set. It is cleared by a write to `reg_addr`=2 with bit 0 set.
- R8: After reset, `sdo_oe`, `sdo`, `irq`, `underrun` and `conflict` are 0. The mask is empty, no buffer is ready, and buffer 0 at index 0 is current.
- R9: A write to `reg_addr`=1 marks buffer 0 ready with bit 0 and buffer 1 ready with bit 1. Ready buffers are used as soon as they become current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bit_en | input | 1 | serial bit tick |
| fsync | input | 1 | frame start, sampled on a tick |
| sdo | output | 1 | serial data |
| sdo_oe | output | 1 | serial data output enable |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 2 | register select: 0 mask, 1 ready, 2 clear |
| reg_wdata | input | NUM_SLOTS | register write data |
| foreign_mask | input | NUM_SLOTS | slots owned by other transmitters |
| mem_rd | output | 1 | memory read strobe |
| mem_addr | output | log2(2*BUF_WORDS) | memory word address {buffer, index} |
| mem_rdata | input | WORD_W | memory read data, same cycle |
| irq | output | 1 | buffer-emptied pulse |
| irq_buf | output | 1 | buffer that was emptied |
| underrun | output | 1 | sticky underrun flag |
| conflict | output | 1 | sticky slot-conflict flag |

## Verification
Frames run with fixed masks: sparse, full and empty. A fixed mask shows that slot counting and idle slots are handled correctly, and the empty mask confirms the line is never driven. Random masks with random buffer contents separate correct dense addressing from skipped or repeated reads. A mask rewritten in the middle of a frame shows whether ownership switches at the frame sync or too early. Withholding refills until both buffers run dry, then refilling, separates zero-fill without pointer advance from a pointer that moves on or stalls. A mask that overlaps the foreign set shows that refused bits are dropped and the conflict flag is raised.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  typedef enum logic [1:0] {
    REG_MASK  = 2'd0,
    REG_READY = 2'd1,
    REG_CLEAR = 2'd2
  } reg_sel_e;

  localparam int CLR_UNDER_BIT    = 0;
  localparam int CLR_CONFLICT_BIT = 1;
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int NUM_SLOTS = 8,
  parameter int WORD_W    = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int BIT_W    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              fsync,
  output logic              nxt_live,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic [BIT_W-1:0]  nxt_bit
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);

  logic              live_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q;

  // position of the bit that begins at the current tick
  always_comb begin
    nxt_live = live_q;
    nxt_slot = slot_q;
    nxt_bit  = bit_q;
    if (fsync) begin
      nxt_live = 1'b1;
      nxt_slot = '0;
      nxt_bit  = '0;
    end else if (live_q) begin
      if (bit_q == LAST_BIT) begin
        nxt_bit = '0;
        if (slot_q == LAST_SLOT) begin
          nxt_live = 1'b0;
        end else begin
          nxt_slot = slot_q + 1'b1;
        end
      end else begin
        nxt_bit = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      slot_q <= '0;
      bit_q  <= '0;
    end else if (bit_en) begin
      live_q <= nxt_live;
      slot_q <= nxt_slot;
      bit_q  <= nxt_bit;
    end
  end
endmodule

// File: rtl/tdm_slot_mask.sv
module tdm_slot_mask #(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [NUM_SLOTS-1:0] wdata,
  input  logic [NUM_SLOTS-1:0] foreign,
  input  logic                 clr_conflict,
  input  logic                 apply,
  output logic [NUM_SLOTS-1:0] eff_mask,
  output logic                 conflict
);
  logic [NUM_SLOTS-1:0] pend_q, pend_n;
  logic [NUM_SLOTS-1:0] act_q, act_n;
  logic                 conf_q, conf_n;

  always_comb begin
    pend_n = pend_q;
    act_n  = act_q;
    conf_n = conf_q & ~clr_conflict;
    if (wr) begin
      pend_n = wdata & ~foreign;
      if (|(wdata & foreign)) conf_n = 1'b1;
    end
    if (apply) act_n = pend_q;
  end

  assign eff_mask = apply ? pend_q : act_q;
  assign conflict = conf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      conf_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      act_q  <= act_n;
      conf_q <= conf_n;
    end
  end
endmodule

// File: rtl/tdm_pingpong.sv
module tdm_pingpong #(
  parameter int BUF_WORDS = 4,
  localparam int IDX_W    = $clog2(BUF_WORDS),
  localparam int AW       = IDX_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [1:0]    ready_set,
  input  logic          clr_under,
  output logic          rd,
  output logic [AW-1:0] addr,
  output logic          have,
  output logic          irq,
  output logic          irq_buf,
  output logic          underrun
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BUF_WORDS - 1);

  logic [1:0]       ready_q, ready_n;
  logic             sel_q, sel_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             irq_q, irq_n;
  logic             ibuf_q, ibuf_n;
  logic             under_q, under_n;

  assign have = ready_q[sel_q];
  assign rd   = take & have;
  assign addr = {sel_q, idx_q};

  always_comb begin
    ready_n = ready_q;
    sel_n   = sel_q;
    idx_n   = idx_q;
    irq_n   = 1'b0;
    ibuf_n  = ibuf_q;
    under_n = under_q & ~clr_under;
    if (take) begin
      if (have) begin
        if (idx_q == LAST_IDX) begin
          ready_n[sel_q] = 1'b0;
          sel_n          = ~sel_q;
          idx_n          = '0;
          irq_n          = 1'b1;
          ibuf_n         = sel_q;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end else begin
        under_n = 1'b1;
      end
    end
    ready_n = ready_n | ready_set;
  end

  assign irq      = irq_q;
  assign irq_buf  = ibuf_q;
  assign underrun = under_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= '0;
      sel_q   <= 1'b0;
      idx_q   <= '0;
      irq_q   <= 1'b0;
      ibuf_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      ready_q <= ready_n;
      sel_q   <= sel_n;
      idx_q   <= idx_n;
      irq_q   <= irq_n;
      ibuf_q  <= ibuf_n;
      under_q <= under_n;
    end
  end
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_tx_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int WORD_W    = 16,
  parameter int BUF_WORDS = 4,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int BIT_W    = $clog2(WORD_W),
  localparam int MEM_AW   = $clog2(BUF_WORDS) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 fsync,
  output logic                 sdo,
  output logic                 sdo_oe,
  input  logic                 reg_we,
  input  logic [1:0]           reg_addr,
  input  logic [NUM_SLOTS-1:0] reg_wdata,
  input  logic [NUM_SLOTS-1:0] foreign_mask,
  output logic                 mem_rd,
  output logic [MEM_AW-1:0]    mem_addr,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 irq,
  output logic                 irq_buf,
  output logic                 underrun,
  output logic                 conflict
);
  logic              nxt_live;
  logic [SLOT_W-1:0] nxt_slot;
  logic [BIT_W-1:0]  nxt_bit;
  logic [NUM_SLOTS-1:0] eff_mask;
  logic mask_wr, ready_wr, clear_wr;
  logic own, take, have;
  logic [WORD_W-1:0] word;

  assign mask_wr  = reg_we && (reg_addr == REG_MASK);
  assign ready_wr = reg_we && (reg_addr == REG_READY);
  assign clear_wr = reg_we && (reg_addr == REG_CLEAR);

  tdm_frame_timer #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
    .nxt_live(nxt_live), .nxt_slot(nxt_slot), .nxt_bit(nxt_bit)
  );

  tdm_slot_mask #(.NUM_SLOTS(NUM_SLOTS)) i_mask (
    .clk(clk), .rst_n(rst_n), .wr(mask_wr), .wdata(reg_wdata),
    .foreign(foreign_mask),
    .clr_conflict(clear_wr & reg_wdata[CLR_CONFLICT_BIT]),
    .apply(bit_en & fsync), .eff_mask(eff_mask), .conflict(conflict)
  );

  assign own  = nxt_live & eff_mask[nxt_slot];
  assign take = bit_en & own & (nxt_bit == '0);

  tdm_pingpong #(.BUF_WORDS(BUF_WORDS)) i_buf (
    .clk(clk), .rst_n(rst_n), .take(take),
    .ready_set(ready_wr ? reg_wdata[1:0] : 2'b00),
    .clr_under(clear_wr & reg_wdata[CLR_UNDER_BIT]),
    .rd(mem_rd), .addr(mem_addr), .have(have),
    .irq(irq), .irq_buf(irq_buf), .underrun(underrun)
  );

  assign word = have ? mem_rdata : '0;

  logic [WORD_W-1:0] sh_q, sh_n;
  logic              sdo_q, sdo_n;
  logic              oe_q, oe_n;

  always_comb begin
    sh_n  = sh_q;
    sdo_n = sdo_q;
    oe_n  = oe_q;
    if (bit_en) begin
      oe_n = own;
      if (take) begin
        sdo_n = word[WORD_W-1];
        sh_n  = {word[WORD_W-2:0], 1'b0};
      end else if (own) begin
        sdo_n = sh_q[WORD_W-1];
        sh_n  = {sh_q[WORD_W-2:0], 1'b0};
      end else begin
        sdo_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      sdo_q <= sdo_n;
      oe_q  <= oe_n;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = oe_q;
endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       sdo,
  input logic       sdo_oe,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [1:0] clr_bits,
  input logic       mem_rd,
  input logic       irq,
  input logic       underrun,
  input logic       conflict
);
  a_r2_released_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(sdo_oe) && $stable(sdo)));

  a_r5_read_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> bit_en);

  a_r5_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> sdo_oe);

  a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r6_irq_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mem_rd));

  a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !(reg_we && reg_addr == 2'd2 && clr_bits[0])) |=> underrun);

  a_r4_conflict_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && !(reg_we && reg_addr == 2'd2 && clr_bits[1])) |=> conflict);
endmodule

bind tdm_slot_tx tdm_slot_tx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sdo(sdo), .sdo_oe(sdo_oe),
  .reg_we(reg_we), .reg_addr(reg_addr), .clr_bits(reg_wdata[1:0]),
  .mem_rd(mem_rd), .irq(irq), .underrun(underrun), .conflict(conflict)
);

// File: tb/test_tdm_slot_tx.sv
module test_tdm_slot_tx;
  localparam int NS = 8;
  localparam int WW = 16;
  localparam int BW = 4;

  logic clk, rst_n, bit_en, fsync, sdo, sdo_oe, reg_we;
  logic [1:0] reg_addr;
  logic [NS-1:0] reg_wdata, foreign_mask;
  logic mem_rd, irq, irq_buf, underrun, conflict;
  logic [2:0] mem_addr;
  logic [WW-1:0] mem_rdata;
  logic [WW-1:0] mem [0:2*BW-1];

  int checks = 0;
  int errors = 0;

  assign mem_rdata = mem[mem_addr];

  tdm_slot_tx #(.NUM_SLOTS(NS), .WORD_W(WW), .BUF_WORDS(BW)) i_tdm_slot_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .foreign_mask(foreign_mask), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .irq(irq), .irq_buf(irq_buf),
    .underrun(underrun), .conflict(conflict)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // bench model state
  logic [NS-1:0] m_act, m_pend;
  logic [1:0]    m_ready;
  logic          m_sel, m_under, m_conf, m_live;
  int            m_idx, m_slot, m_bit;
  logic [WW-1:0] m_word;
  logic          refill;
  string         oe_tag;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [NS-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      2'd0: begin
        m_pend = d & ~foreign_mask;
        if ((d & foreign_mask) != '0) m_conf = 1'b1;
      end
      2'd1: m_ready = m_ready | d[1:0];
      2'd2: begin
        if (d[0]) m_under = 1'b0;
        if (d[1]) m_conf = 1'b0;
      end
      default: ;
    endcase
  endtask

  task automatic fill(input int b);
    for (int i = 0; i < BW; i++) mem[b*BW+i] = WW'($urandom);
  endtask

  // one serial bit: model, drive tick, check outputs after the edge
  task automatic tick(input logic fs);
    logic own, exp_irq, exp_ib, exp_sdo;
    string wtag;
    exp_irq = 1'b0; exp_ib = 1'b0; wtag = "R5";
    if (fs) begin
      m_live = 1'b1; m_slot = 0; m_bit = 0; m_act = m_pend;
    end else if (m_live) begin
      if (m_bit == WW-1) begin
        m_bit = 0;
        if (m_slot == NS-1) m_live = 1'b0; else m_slot++;
      end else m_bit++;
    end
    own = m_live && m_act[m_slot];
    if (own && m_bit == 0) begin
      if (m_ready[m_sel]) begin
        m_word = mem[int'(m_sel)*BW + m_idx];
        m_idx++;
        if (m_idx == BW) begin
          m_ready[m_sel] = 1'b0; exp_irq = 1'b1; exp_ib = m_sel;
          m_sel = ~m_sel; m_idx = 0;
        end
      end else begin
        m_word = '0; m_under = 1'b1;
      end
    end
    if (own && !m_ready[m_sel] && m_word == '0) wtag = "R7";
    exp_sdo = own ? m_word[WW-1-m_bit] : 1'b0;
    @(negedge clk);
    bit_en = 1'b1; fsync = fs;
    @(negedge clk);
    bit_en = 1'b0; fsync = 1'b0;
    chk(oe_tag, "sdo_oe", sdo_oe, own);
    chk(own ? wtag : "R2", "sdo", sdo, exp_sdo);
    chk("R6", "irq", irq, exp_irq);
    if (exp_irq) chk("R6", "irq_buf", irq_buf, exp_ib);
    chk("R7", "underrun", underrun, m_under);
  endtask

  task automatic send_frame(input int mid_slot, input logic [NS-1:0] mid_mask);
    for (int s = 0; s < NS; s++)
      for (int b = 0; b < WW; b++) begin
        if (b == 0 && s == mid_slot) reg_write(2'd0, mid_mask);
        tick(s == 0 && b == 0);
      end
    if (refill)
      for (int b = 0; b < 2; b++)
        if (!m_ready[b]) begin
          fill(b);
          reg_write(2'd1, NS'(1 << b));
        end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run got %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; bit_en = 1'b0; fsync = 1'b0; reg_we = 1'b0;
    reg_addr = '0; reg_wdata = '0; foreign_mask = '0;
    m_act = '0; m_pend = '0; m_ready = '0; m_sel = 1'b0; m_under = 1'b0;
    m_conf = 1'b0; m_live = 1'b0; m_idx = 0; m_slot = 0; m_bit = 0;
    m_word = '0; refill = 1'b1; oe_tag = "R2";
    for (int i = 0; i < 2*BW; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8", "sdo_oe", sdo_oe, 0);
    chk("R8", "sdo", sdo, 0);
    chk("R8", "irq", irq, 0);
    chk("R8", "underrun", underrun, 0);
    chk("R8", "conflict", conflict, 0);
    chk("R8", "mem_addr", mem_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 ticks before any frame sync drive nothing
    oe_tag = "R1";
    for (int i = 0; i < 5; i++) tick(1'b0);

    // R9 fill and mark both buffers, sparse fixed mask
    fill(0); fill(1);
    reg_write(2'd1, NS'(3));
    oe_tag = "R2";
    reg_write(2'd0, 8'b1010_0110);
    for (int f = 0; f < 3; f++) send_frame(-1, '0);

    // R1 ticks after the last slot without a new frame sync
    oe_tag = "R1";
    for (int i = 0; i < 20; i++) tick(1'b0);

    // R3 mid-frame mask change applies at the next frame sync
    oe_tag = "R3";
    send_frame(3, 8'hFF);
    send_frame(5, 8'h01);
    send_frame(-1, '0);

    // R4 conflicting request
    oe_tag = "R4";
    foreign_mask = 8'h0F;
    reg_write(2'd0, 8'h3C);
    chk("R4", "conflict", conflict, 1);
    send_frame(-1, '0);
    chk("R4", "conflict held", conflict, 1);
    reg_write(2'd2, 8'h02);
    chk("R4", "conflict cleared", conflict, 0);
    reg_write(2'd0, 8'hC0);
    chk("R4", "no conflict", conflict, 0);
    foreign_mask = '0;

    // R7 underrun: stop refilling until both buffers are dry
    oe_tag = "R7";
    reg_write(2'd0, 8'hFF);
    refill = 1'b0;
    for (int f = 0; f < 3; f++) send_frame(-1, '0);
    chk("R7", "underrun set", underrun, 1);
    // R9 refill resumes output; flag stays until cleared
    refill = 1'b1;
    fill(0); fill(1);
    reg_write(2'd1, NS'(3));
    oe_tag = "R9";
    send_frame(-1, '0);
    chk("R7", "underrun sticky", underrun, 1);
    reg_write(2'd2, 8'h01);
    chk("R7", "underrun cleared", underrun, 0);

    // R2 empty mask never drives
    oe_tag = "R2";
    reg_write(2'd0, 8'h00);
    send_frame(-1, '0);
    send_frame(-1, '0);

    // R5 random masks, mid-frame changes and refills
    oe_tag = "R5";
    for (int f = 0; f < 12; f++) begin
      logic [NS-1:0] rm;
      rm = NS'($urandom);
      if ((f % 3) == 0) send_frame(int'($urandom_range(1, NS-1)), rm);
      else begin
        reg_write(2'd0, rm);
        send_frame(-1, '0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule